// File: doc/BRIEF.md
# Processor status and exception entry controller

This block holds the processor's current status word and runs the three ways the processor can be forced off its normal instruction stream. These are release from reset, the fast interrupt and the normal interrupt. The status word carries a 5-bit mode field, two interrupt-mask bits and an instruction-state bit. The instruction-state bit selects between the 16-bit compressed instruction set and the 32-bit instruction set, and it is also driven out as a pin. Each kind of entry has its own saved-status register and link register. The outputs of these registers are visible at the ports.

Both interrupt request lines are asynchronous and pass through a fixed-depth synchronizer. A request is considered only on a cycle where the core signals an instruction boundary. The fast interrupt wins when both requests are present. Once a request is accepted, a fixed entry time runs. A pending data-abort entry adds a further delay. When the entry commits, the block writes the banked registers, loads a new status value, places the vector on `vec_addr` and the fetch address, and pulses `redirect` for one cycle. The reset input is synchronous and active low. While it is low, the fetch address keeps stepping. On release, the old program counter and status word are saved into the supervisor bank and fetching restarts at address zero.

Top module: `psr_exc_ctrl`

## Requirements
- R1: `st_word` is laid out as bit 7 = normal-interrupt mask, bit 6 = fast-interrupt mask, bit 5 = instruction state (1 = 16-bit set), bits 4:0 = mode. `t_state` equals bit 5. When no entry commits, a cycle with `st_we` high loads `st_wdata` at that edge, and otherwise the status word holds.
- R2: While `rst_n` is low at a clock edge, `fetch_addr` grows by 4 at that edge and `redirect` is 0.
- R3: At the first edge with `rst_n` high after reset, `svc_lr` takes `cur_pc` and `svc_spsr` takes the status word held before that edge.
- R4: At that same edge, the status word becomes 8'hD3 (mode 5'b10011, both masks set, state bit clear). `fetch_addr` and `vec_addr` become 0, and `redirect` is high for the one following cycle.
- R5: Each request line passes through a 4-stage synchronizer. A request first raised before edge 1 can be accepted at edge 5 at the earliest.
- R6: A normal interrupt is ignored while bit 7 is set. A fast interrupt is ignored while bit 6 is set.
- R7: A request is accepted only at an edge where `insn_bound` is high. When both requests are unmasked, the fast interrupt is chosen.
- R8: `redirect` rises 2 cycles after the accepting edge. When `abort_pend` is high at the accepting edge, the delay is 5 cycles.
- R9: A fast-interrupt entry gives `vec_addr` = 32'h1C and status 8'hD1 (mode 5'b10001, both masks set, state bit clear). `fiq_lr` gets `cur_pc` from the accepting edge, and `fiq_spsr` gets the status word held just before the entry commits.
- R10: A normal-interrupt entry gives `vec_addr` = 32'h18 and mode 5'b10010. It sets bit 7, clears bit 5 and leaves bit 6 unchanged. `irq_lr` and `irq_spsr` are filled in the same way as the fast-interrupt bank.
- R11: Outside reset, `fetch_addr` grows by 4 every cycle, except at an entry edge, where it loads the vector instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Normal interrupt request, asynchronous |
| fiq_req | input | 1 | Fast interrupt request, asynchronous |
| insn_bound | input | 1 | High when the core is at an instruction boundary |
| abort_pend | input | 1 | Data-abort entry pending; lengthens an entry |
| cur_pc | input | 32 | PC of the next instruction |
| st_we | input | 1 | Status word write strobe |
| st_wdata | input | 8 | Status word write value |
| st_word | output | 8 | Current status word |
| t_state | output | 1 | Instruction-state indicator |
| redirect | output | 1 | One-cycle pulse when the fetch stream is redirected |
| vec_addr | output | 32 | Vector address of the last entry |
| fetch_addr | output | 32 | Current fetch address |
| svc_lr | output | 32 | Supervisor link register |
| svc_spsr | output | 8 | Supervisor saved status |
| irq_lr | output | 32 | Normal-interrupt link register |
| irq_spsr | output | 8 | Normal-interrupt saved status |
| fiq_lr | output | 32 | Fast-interrupt link register |
| fiq_spsr | output | 8 | Fast-interrupt saved status |

## Verification
Reset results are due one edge after `rst_n` rises, so the bench samples one cycle after the release. An interrupt request raised while the boundary strobe is held high must give `redirect` after exactly 7 edges, or after 10 edges with an abort pending. The bench counts the edges up to the pulse and compares that count, so an early entry fails the check as surely as a late one. When the boundary strobe is raised late, the pulse is due 3 edges after the strobe, and the fetch address is checked one edge after each entry. Masked requests are watched for 20 edges, which is well past the longest delay.

// File: rtl/psr_exc_pkg.sv
`timescale 1ns/1ps
package psr_exc_pkg;
   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_IRQ = 5'b10010;

   typedef struct packed {
      logic       imask;
      logic       fmask;
      logic       thumb;
      logic [4:0] mode;
   } stat_t;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_IRQ  = 2'd1,
      EV_FIQ  = 2'd2
   } ev_t;
endpackage

// File: rtl/psr_req_sync.sv
`timescale 1ns/1ps
module psr_req_sync #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [DEPTH-1:0] stg;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("psr_req_sync: DEPTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[DEPTH-2:0], d};
   end

   assign q = stg[DEPTH-1];
endmodule

// File: rtl/psr_exc_pick.sv
`timescale 1ns/1ps
module psr_exc_pick
   import psr_exc_pkg::*;
(
   input  logic fiq_s,
   input  logic irq_s,
   input  logic fmask,
   input  logic imask,
   input  logic bound,
   input  logic idle,
   output ev_t  ev
);
   always_comb begin
      ev = EV_NONE;
      if (bound && idle) begin
         if (fiq_s && !fmask)      ev = EV_FIQ;
         else if (irq_s && !imask) ev = EV_IRQ;
      end
   end
endmodule

// File: rtl/psr_exc_seq.sv
`timescale 1ns/1ps
module psr_exc_seq #(
   parameter int ENTRY_CYC = 2,
   parameter int ABORT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic busy,
   output logic commit
);
   localparam int CW = $clog2(ENTRY_CYC + ABORT_CYC + 1);
   localparam logic [CW-1:0] LD_PLAIN = CW'(ENTRY_CYC - 1);
   localparam logic [CW-1:0] LD_ABORT = CW'(ENTRY_CYC + ABORT_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= abort ? LD_ABORT : LD_PLAIN;
         end
      end else if (cnt == '0) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign commit = busy && (cnt == '0);
endmodule

// File: rtl/psr_exc_ctrl.sv
`timescale 1ns/1ps
module psr_exc_ctrl
   import psr_exc_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          SYNC_LEN   = 4,
   parameter int          ENTRY_CYC  = 2,
   parameter int          ABORT_CYC  = 3,
   parameter int          FETCH_STEP = 4,
   parameter logic [31:0] RST_VEC    = 32'h0000_0000,
   parameter logic [31:0] IRQ_VEC    = 32'h0000_0018,
   parameter logic [31:0] FIQ_VEC    = 32'h0000_001C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq_req,
   input  logic          fiq_req,
   input  logic          insn_bound,
   input  logic          abort_pend,
   input  logic [AW-1:0] cur_pc,
   input  logic          st_we,
   input  logic [7:0]    st_wdata,
   output logic [7:0]    st_word,
   output logic          t_state,
   output logic          redirect,
   output logic [AW-1:0] vec_addr,
   output logic [AW-1:0] fetch_addr,
   output logic [AW-1:0] svc_lr,
   output logic [7:0]    svc_spsr,
   output logic [AW-1:0] irq_lr,
   output logic [7:0]    irq_spsr,
   output logic [AW-1:0] fiq_lr,
   output logic [7:0]    fiq_spsr
);
   localparam logic [AW-1:0] STEP = AW'(FETCH_STEP);
   localparam logic [AW-1:0] V_RST = AW'(RST_VEC);
   localparam logic [AW-1:0] V_IRQ = AW'(IRQ_VEC);
   localparam logic [AW-1:0] V_FIQ = AW'(FIQ_VEC);

   generate
      if (SYNC_LEN < 2 || SYNC_LEN > 4) begin : g_bad_sync
         $error("psr_exc_ctrl: SYNC_LEN must lie in 2..4");
      end
      if (ENTRY_CYC < 1) begin : g_bad_entry
         $error("psr_exc_ctrl: ENTRY_CYC must be at least 1");
      end
      if (AW < 8) begin : g_bad_aw
         $error("psr_exc_ctrl: AW too small for vectors");
      end
   endgenerate

   stat_t         st;
   logic          rst_pend;
   logic          fiq_s, irq_s;
   logic          busy, commit, accept;
   ev_t           ev, ev_hold;
   logic [AW-1:0] lr_hold;

   psr_req_sync #(.DEPTH(SYNC_LEN)) u_sync_fiq (
      .clk(clk), .rst_n(rst_n), .d(fiq_req), .q(fiq_s));
   psr_req_sync #(.DEPTH(SYNC_LEN)) u_sync_irq (
      .clk(clk), .rst_n(rst_n), .d(irq_req), .q(irq_s));

   psr_exc_pick u_pick (
      .fiq_s(fiq_s), .irq_s(irq_s), .fmask(st.fmask), .imask(st.imask),
      .bound(insn_bound), .idle(!busy && !rst_pend), .ev(ev));

   assign accept = (ev != EV_NONE);

   psr_exc_seq #(.ENTRY_CYC(ENTRY_CYC), .ABORT_CYC(ABORT_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .abort(abort_pend),
      .busy(busy), .commit(commit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_pend   <= 1'b1;
         redirect   <= 1'b0;
         fetch_addr <= fetch_addr + STEP;
      end else if (rst_pend) begin
         rst_pend   <= 1'b0;
         svc_lr     <= cur_pc;
         svc_spsr   <= st;
         st         <= '{imask: 1'b1, fmask: 1'b1, thumb: 1'b0, mode: MODE_SVC};
         fetch_addr <= V_RST;
         vec_addr   <= V_RST;
         redirect   <= 1'b1;
      end else begin
         redirect   <= 1'b0;
         fetch_addr <= fetch_addr + STEP;
         if (commit) begin
            redirect <= 1'b1;
            if (ev_hold == EV_FIQ) begin
               fiq_lr     <= lr_hold;
               fiq_spsr   <= st;
               st         <= '{imask: 1'b1, fmask: 1'b1, thumb: 1'b0, mode: MODE_FIQ};
               vec_addr   <= V_FIQ;
               fetch_addr <= V_FIQ;
            end else begin
               irq_lr     <= lr_hold;
               irq_spsr   <= st;
               st         <= '{imask: 1'b1, fmask: st.fmask, thumb: 1'b0, mode: MODE_IRQ};
               vec_addr   <= V_IRQ;
               fetch_addr <= V_IRQ;
            end
         end else if (st_we) begin
            st <= stat_t'(st_wdata);
         end
         if (accept) begin
            ev_hold <= ev;
            lr_hold <= cur_pc;
         end
      end
   end

   assign st_word = st;
   assign t_state = st.thumb;
endmodule

// File: rtl/psr_exc_ctrl_chk.sv
`timescale 1ns/1ps
module psr_exc_ctrl_chk #(
   parameter int          AW         = 32,
   parameter int          FETCH_STEP = 4,
   parameter logic [31:0] RST_VEC    = 32'h0,
   parameter logic [31:0] IRQ_VEC    = 32'h18,
   parameter logic [31:0] FIQ_VEC    = 32'h1C
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_we,
   input logic [7:0]    st_word,
   input logic          redirect,
   input logic [AW-1:0] vec_addr,
   input logic [AW-1:0] fetch_addr
);
   // R4
   rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && vec_addr == AW'(RST_VEC)) |-> (st_word == 8'hD3 && fetch_addr == AW'(RST_VEC)));

   // R9
   fiq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && vec_addr == AW'(FIQ_VEC)) |-> (st_word == 8'hD1 && fetch_addr == AW'(FIQ_VEC)));

   // R10
   irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && vec_addr == AW'(IRQ_VEC)) |-> (st_word[4:0] == 5'b10010 && st_word[7] && !st_word[5]));

   // R4
   redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> !redirect);

   // R1
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!redirect && !$past(st_we)) |-> $stable(st_word));

   // R11
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!redirect && $past(rst_n)) |-> (fetch_addr == $past(fetch_addr) + AW'(FETCH_STEP)));
endmodule

bind psr_exc_ctrl psr_exc_ctrl_chk #(
   .AW(AW), .FETCH_STEP(FETCH_STEP), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC), .FIQ_VEC(FIQ_VEC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_word(st_word),
   .redirect(redirect), .vec_addr(vec_addr), .fetch_addr(fetch_addr)
);

// File: tb/psr_exc_ctrl_test.sv
`timescale 1ns/1ps
module psr_exc_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0, fiq_req = 1'b0, insn_bound = 1'b0, abort_pend = 1'b0;
   logic [31:0] cur_pc = '0;
   logic        st_we = 1'b0;
   logic [7:0]  st_wdata = '0;
   logic [7:0]  st_word, svc_spsr, irq_spsr, fiq_spsr;
   logic        t_state, redirect;
   logic [31:0] vec_addr, fetch_addr, svc_lr, irq_lr, fiq_lr;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   psr_exc_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fiq_req(fiq_req),
      .insn_bound(insn_bound), .abort_pend(abort_pend), .cur_pc(cur_pc),
      .st_we(st_we), .st_wdata(st_wdata), .st_word(st_word), .t_state(t_state),
      .redirect(redirect), .vec_addr(vec_addr), .fetch_addr(fetch_addr),
      .svc_lr(svc_lr), .svc_spsr(svc_spsr), .irq_lr(irq_lr), .irq_spsr(irq_spsr),
      .fiq_lr(fiq_lr), .fiq_spsr(fiq_spsr));

   typedef struct packed {
      logic [7:0]  st;
      logic        fiq;
      logic        irq;
      logic        ab;
      logic        taken;
      logic [7:0]  lat;
      logic [31:0] vec;
      logic [7:0]  est;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t TBL [NV] = '{
      '{8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7,  32'h1C, 8'hD1},
      '{8'h10, 1'b0, 1'b1, 1'b0, 1'b1, 8'd7,  32'h18, 8'h92},
      '{8'h10, 1'b1, 1'b1, 1'b0, 1'b1, 8'd7,  32'h1C, 8'hD1},
      '{8'h50, 1'b1, 1'b1, 1'b0, 1'b1, 8'd7,  32'h18, 8'hD2},
      '{8'h90, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  32'h0,  8'h90},
      '{8'h50, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0,  32'h0,  8'h50},
      '{8'h30, 1'b1, 1'b0, 1'b1, 1'b1, 8'd10, 32'h1C, 8'hD1},
      '{8'h20, 1'b0, 1'b1, 1'b1, 1'b1, 8'd10, 32'h18, 8'h92}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_status(input logic [7:0] v);
      st_we = 1'b1;
      st_wdata = v;
      step();
      st_we = 1'b0;
   endtask

   task automatic flush();
      fiq_req = 1'b0;
      irq_req = 1'b0;
      insn_bound = 1'b0;
      abort_pend = 1'b0;
      for (int k = 0; k < 6; k++) step();
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] fa;
      int lat;

      // Reset and first release
      for (int k = 0; k < 3; k++) step();
      chk("R2 no redirect in reset", {31'b0, redirect}, 32'h0);
      cur_pc = 32'h100;
      rst_n = 1'b1;
      step();
      chk("R4 release status", {24'b0, st_word}, 32'hD3);
      chk("R4 release redirect", {31'b0, redirect}, 32'h1);
      chk("R4 release fetch", fetch_addr, 32'h0);
      chk("R4 release vector", vec_addr, 32'h0);
      chk("R3 svc link", svc_lr, 32'h100);
      step();
      chk("R4 redirect one cycle", {31'b0, redirect}, 32'h0);
      chk("R11 fetch step", fetch_addr, 32'h4);

      // Status write, then a second reset that saves it
      wr_status(8'h3F);
      chk("R1 status write", {24'b0, st_word}, 32'h3F);
      chk("R1 state pin", {31'b0, t_state}, 32'h1);
      fa = fetch_addr;
      rst_n = 1'b0;
      for (int k = 0; k < 3; k++) step();
      chk("R2 fetch steps in reset", fetch_addr, fa + 32'd12);
      chk("R2 no redirect in reset", {31'b0, redirect}, 32'h0);
      cur_pc = 32'h2000;
      rst_n = 1'b1;
      step();
      chk("R3 svc link", svc_lr, 32'h2000);
      chk("R3 svc saved status", {24'b0, svc_spsr}, 32'h3F);
      chk("R4 status after release", {24'b0, st_word}, 32'hD3);
      chk("R4 state pin clear", {31'b0, t_state}, 32'h0);
      step();

      // Table walk
      for (int i = 0; i < NV; i++) begin
         wr_status(TBL[i].st);
         cur_pc = 32'h4000 + 32'(i * 16);
         fiq_req = TBL[i].fiq;
         irq_req = TBL[i].irq;
         abort_pend = TBL[i].ab;
         insn_bound = 1'b1;
         lat = 0;
         for (int k = 1; k <= 20; k++) begin
            step();
            if (redirect) begin
               lat = k;
               break;
            end
         end
         if (!TBL[i].taken) begin
            chk("R6 masked request ignored", 32'(lat), 32'h0);
            chk("R6 status untouched", {24'b0, st_word}, {24'b0, TBL[i].est});
         end else begin
            chk("R5 R8 entry latency", 32'(lat), {24'b0, TBL[i].lat});
            if (TBL[i].vec == 32'h1C) begin
               chk("R7 R9 fast vector", vec_addr, 32'h1C);
               chk("R9 fast status", {24'b0, st_word}, {24'b0, TBL[i].est});
               chk("R9 fast link", fiq_lr, cur_pc);
               chk("R9 fast saved status", {24'b0, fiq_spsr}, {24'b0, TBL[i].st});
            end else begin
               chk("R10 normal vector", vec_addr, 32'h18);
               chk("R10 normal status", {24'b0, st_word}, {24'b0, TBL[i].est});
               chk("R10 normal link", irq_lr, cur_pc);
               chk("R10 normal saved status", {24'b0, irq_spsr}, {24'b0, TBL[i].st});
            end
            chk("R9 R10 state pin clear", {31'b0, t_state}, 32'h0);
            step();
            chk("R11 fetch after entry", fetch_addr, TBL[i].vec + 32'd4);
         end
         flush();
      end

      // Boundary gating: request waits for the strobe
      wr_status(8'h10);
      cur_pc = 32'h8000;
      fiq_req = 1'b1;
      lat = 0;
      for (int k = 0; k < 12; k++) begin
         step();
         if (redirect) lat = 1;
      end
      chk("R7 no entry without boundary", 32'(lat), 32'h0);
      insn_bound = 1'b1;
      lat = 0;
      for (int k = 1; k <= 10; k++) begin
         step();
         if (redirect) begin
            lat = k;
            break;
         end
      end
      chk("R7 R8 entry after boundary", 32'(lat), 32'h3);
      chk("R9 fast link", fiq_lr, 32'h8000);
      step();
      chk("R11 fetch after entry", fetch_addr, 32'h20);
      flush();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule